// File: doc/BRIEF.md
# PS/2 Keyboard Scan Code Receiver

This block takes the two open-collector lines of a PS/2 keyboard and recovers the bytes the keyboard sends. The keyboard owns its clock line and toggles it at 10 to 16.7 kHz, so the high and low phases each last 30 to 50 µs. The block runs on a fast system clock and passes both lines through flop synchronisers. It detects each falling edge of the keyboard clock. A fixed delay later (1250 cycles, or 25 µs at 50 MHz), it samples the data line, near the middle of the bit cell.

A frame has eleven cells: a start bit at 0, eight data bits sent least significant bit first, a parity bit and a stop bit. The parity bit is sampled and then thrown away. When the stop cell is sampled, the assembled byte moves in parallel into an output register and a valid flag rises. The host clears the flag with a one-cycle read strobe. If the keyboard clock stays quiet for too long in the middle of a frame, the receiver gives up on that frame and waits for a new start bit.

The control state machine has four states:
- `RX_IDLE`: waiting for the start cell.
- `RX_DATA`: eight data cells.
- `RX_PARITY`: the parity cell.
- `RX_STOP`: the stop cell.

It has these transitions:
- start-accept: `RX_IDLE`→`RX_DATA`, taken when a 0 is sampled.
- start-reject: `RX_IDLE`→`RX_IDLE`, taken when a 1 is sampled.
- data-full: `RX_DATA`→`RX_PARITY`, taken after the eighth data sample.
- parity-skip: `RX_PARITY`→`RX_STOP`.
- frame-end: `RX_STOP`→`RX_IDLE`. This transition latches the byte.
- gap-timeout: any busy state→`RX_IDLE`.

Top module: `ps2_scan_receiver`

## Requirements
- R1: While reset is held, and right after it, `code_valid` is 0 and `code_out` is 8'h00.
- R2: Each frame takes eleven data samples. The samples are one start sample at 0, eight data samples placed LSB first (the first data sample lands in `code_out[0]`), one parity sample and one stop sample. The byte appears on `code_out` at the stop sample.
- R3: Every sample is taken `SAMPLE_DELAY` system clocks after a keyboard clock falling edge is detected. The byte and the flag update at the rising system clock edge that comes `SAMPLE_DELAY + 2` cycles after the first edge at which `kb_clk` reads 0 for the stop cell. `SAMPLE_DELAY` must be at least 2.
- R4: The parity cell has no effect. A frame with wrong parity delivers its byte in the same cycle, and with the same flag behaviour, as a frame with correct parity.
- R5: If the start sample reads 1, it is discarded and the receiver stays waiting for a start cell. A following well-formed frame is delivered correctly.
- R6: `code_valid` rises only at the cycle a byte is latched. A `rd_strobe` held during one rising edge clears it at that edge. If a latch and a read meet at the same edge, the latch wins and the flag stays 1.
- R7: If no keyboard clock falling edge arrives for `GAP_TIMEOUT` cycles while a frame is in progress, the partial frame is dropped and the receiver waits for a new start cell.
- R8: `code_out` holds its value between latches. A new frame overwrites it even if `code_valid` was never cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| kb_clk | input | 1 | Keyboard clock line, asynchronous, idle high |
| kb_data | input | 1 | Keyboard data line, asynchronous, idle high |
| rd_strobe | input | 1 | Host read, one cycle, clears `code_valid` |
| code_out | output | 8 | Last received scan code byte |
| code_valid | output | 1 | A byte has been latched and not yet read |

## Verification
The bench builds the receiver with `SAMPLE_DELAY` = 8 and `GAP_TIMEOUT` = 200. It drives a keyboard half-period of 20 system cycles, so each cell is sampled well inside its low phase. With these values an abandoned partial frame reaches the timeout after a few hundred cycles instead of 100,000. The short delay also keeps the exact latch cycle of R3 easy to place, including the case where a read lands on the same edge as the latch.

// File: rtl/ps2rx_pkg.sv
package ps2rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_DATA   = 2'd1,
        RX_PARITY = 2'd2,
        RX_STOP   = 2'd3
    } rx_state_t;

    localparam int SCAN_BITS = 8;

endpackage

// File: rtl/ps2rx_sync.sv
module ps2rx_sync #(
    parameter int              WIDTH     = 2,
    parameter int              STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    genvar g;
    generate
        for (g = 0; g < WIDTH; g++) begin : g_line
            logic [STAGES-1:0] chain;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain <= {STAGES{RESET_VAL[g]}};
                end else begin
                    chain <= {chain[STAGES-2:0], din[g]};
                end
            end

            assign dout[g] = chain[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/ps2rx_sampler.sv
module ps2rx_sampler #(
    parameter int SAMPLE_DELAY = 1250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_clk,
    output logic fall_seen,
    output logic sample_en
);

    localparam int DLY_W = (SAMPLE_DELAY > 2) ? $clog2(SAMPLE_DELAY) : 1;
    localparam logic [DLY_W-1:0] DLY_LOAD = DLY_W'(SAMPLE_DELAY - 1);

    logic             line_prev;
    logic             armed;
    logic [DLY_W-1:0] dly_cnt;

    assign fall_seen = line_prev && !line_clk;
    assign sample_en = armed && (dly_cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_prev <= 1'b1;
        end else begin
            line_prev <= line_clk;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed   <= 1'b0;
            dly_cnt <= '0;
        end else if (fall_seen) begin
            armed   <= 1'b1;
            dly_cnt <= DLY_LOAD;
        end else if (sample_en) begin
            armed   <= 1'b0;
        end else if (armed) begin
            dly_cnt <= dly_cnt - 1'b1;
        end
    end

    // R3: one sample per falling edge, never two in a row
    a_r3_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |=> !sample_en);

endmodule

// File: rtl/ps2rx_fsm.sv
module ps2rx_fsm
    import ps2rx_pkg::*;
#(
    parameter int GAP_TIMEOUT = 100000,
    parameter int DATA_BITS   = SCAN_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall_seen,
    input  logic                 sample_en,
    input  logic                 data_bit,
    output logic                 frame_done,
    output logic [DATA_BITS-1:0] frame_byte
);

    localparam int GAP_W = $clog2(GAP_TIMEOUT);
    localparam int IDX_W = $clog2(DATA_BITS);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_TIMEOUT - 1);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    rx_state_t            state, state_nx;
    logic [GAP_W-1:0]     gap_cnt;
    logic [IDX_W-1:0]     bit_idx;
    logic [DATA_BITS-1:0] shreg;
    logic                 gap_hit;

    assign gap_hit    = (state != RX_IDLE) && !fall_seen && (gap_cnt == GAP_LAST);
    assign frame_done = (state == RX_STOP) && sample_en && !gap_hit;
    assign frame_byte = shreg;

    always_comb begin
        state_nx = state;
        if (gap_hit) begin
            state_nx = RX_IDLE;
        end else begin
            unique case (state)
                RX_IDLE:   if (sample_en && !data_bit)         state_nx = RX_DATA;
                RX_DATA:   if (sample_en && bit_idx == IDX_LAST) state_nx = RX_PARITY;
                RX_PARITY: if (sample_en)                      state_nx = RX_STOP;
                RX_STOP:   if (sample_en)                      state_nx = RX_IDLE;
                default:                                       state_nx = RX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            bit_idx <= '0;
            shreg   <= '0;
        end else begin
            if (state == RX_IDLE || fall_seen) begin
                gap_cnt <= '0;
            end else if (!gap_hit) begin
                gap_cnt <= gap_cnt + 1'b1;
            end

            unique case (state)
                RX_IDLE: begin
                    bit_idx <= '0;
                end
                RX_DATA: begin
                    if (sample_en && !gap_hit) begin
                        shreg   <= {data_bit, shreg[DATA_BITS-1:1]};
                        bit_idx <= bit_idx + 1'b1;
                    end
                end
                RX_PARITY: begin
                    bit_idx <= '0;
                end
                RX_STOP: begin
                    bit_idx <= '0;
                end
                default: begin
                    bit_idx <= '0;
                end
            endcase
        end
    end

    // R5: a start sample of 1 keeps the receiver waiting
    a_r5_start_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RX_IDLE && sample_en && data_bit) |=> (state == RX_IDLE));

    // R7: a silent keyboard clock ends a partial frame
    a_r7_gap_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state != RX_IDLE && gap_cnt == GAP_LAST && !fall_seen) |=> (state == RX_IDLE));

endmodule

// File: rtl/ps2_scan_receiver.sv
module ps2_scan_receiver
    import ps2rx_pkg::*;
#(
    parameter int SAMPLE_DELAY = 1250,
    parameter int GAP_TIMEOUT  = 100000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 kb_clk,
    input  logic                 kb_data,
    input  logic                 rd_strobe,
    output logic [SCAN_BITS-1:0] code_out,
    output logic                 code_valid
);

    logic [1:0]           lines_s;
    logic                 fall_seen;
    logic                 sample_en;
    logic                 frame_done;
    logic [SCAN_BITS-1:0] frame_byte;

    ps2rx_sync #(
        .WIDTH     (2),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({kb_data, kb_clk}),
        .dout  (lines_s)
    );

    ps2rx_sampler #(
        .SAMPLE_DELAY (SAMPLE_DELAY)
    ) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_clk  (lines_s[0]),
        .fall_seen (fall_seen),
        .sample_en (sample_en)
    );

    ps2rx_fsm #(
        .GAP_TIMEOUT (GAP_TIMEOUT),
        .DATA_BITS   (SCAN_BITS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_seen  (fall_seen),
        .sample_en  (sample_en),
        .data_bit   (lines_s[1]),
        .frame_done (frame_done),
        .frame_byte (frame_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_out   <= '0;
            code_valid <= 1'b0;
        end else if (frame_done) begin
            code_out   <= frame_byte;
            code_valid <= 1'b1;
        end else if (rd_strobe) begin
            code_valid <= 1'b0;
        end
    end

    // R6: the flag only rises at a latch
    a_r6_rise_needs_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(code_valid) |-> $past(frame_done));

    // R6: a read without a latch clears the flag
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !frame_done) |=> !code_valid);

    // R8: the code holds between latches
    a_r8_code_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(code_out));

endmodule

// File: tb/ps2_scan_receiver_bench.sv
`timescale 1ns/1ps
module ps2_scan_receiver_bench;

    localparam int DLY  = 8;
    localparam int GAP  = 200;
    localparam int HALF = 20;
    localparam int LAT  = DLY + 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       kb_clk = 1'b1;
    logic       kb_data = 1'b1;
    logic       rd_strobe = 1'b0;
    logic [7:0] code_out;
    logic       code_valid;

    ps2_scan_receiver #(
        .SAMPLE_DELAY (DLY),
        .GAP_TIMEOUT  (GAP),
        .SYNC_STAGES  (2)
    ) u_ps2_scan_receiver (
        .clk        (clk),
        .rst_n      (rst_n),
        .kb_clk     (kb_clk),
        .kb_data    (kb_data),
        .rd_strobe  (rd_strobe),
        .code_out   (code_out),
        .code_valid (code_valid)
    );

    always #2.5 clk = ~clk;

    int     cyc = 0;
    int     vectors = 0;
    int     errors = 0;
    bit     running = 0;
    bit     done = 0;
    bit     rd_seen = 0;
    string  cur_req = "R2";

    int     due_q[$];
    logic [7:0] byte_q[$];
    logic [7:0] exp_code = 8'h00;
    bit         exp_valid = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        rd_seen = rd_strobe;
    end

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual valid/code=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    // reference model, compared on every clock
    always @(negedge clk) begin
        if (running && !done) begin
            if (rd_seen) exp_valid = 0;
            while (due_q.size() > 0 && due_q[0] <= cyc) begin
                void'(due_q.pop_front());
                exp_code  = byte_q.pop_front();
                exp_valid = 1;
            end
            check(cur_req, {code_valid, code_out}, {exp_valid, exp_code});
        end
    end

    task automatic one_cell(input logic b, input bit last, input logic [7:0] byt, input bit rd_latch);
        int due;
        @(negedge clk);
        kb_data = b;
        repeat (HALF) @(negedge clk);
        kb_clk = 1'b0;
        due = cyc + LAT;
        if (last) begin
            due_q.push_back(due);
            byte_q.push_back(byt);
        end
        for (int i = 0; i < HALF; i++) begin
            @(negedge clk);
            rd_strobe = (last && rd_latch && cyc == due - 1);
        end
        rd_strobe = 1'b0;
        kb_clk = 1'b1;
    endtask

    task automatic send_frame(input logic [7:0] byt, input bit bad_par, input bit rd_latch);
        logic par;
        par = (~^byt) ^ bad_par;
        one_cell(1'b0, 0, byt, 0);
        for (int i = 0; i < 8; i++) one_cell(byt[i], 0, byt, 0);
        one_cell(par, 0, byt, 0);
        one_cell(1'b1, 1, byt, rd_latch);
        @(negedge clk);
        kb_data = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic host_read();
        @(negedge clk);
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual cycle=%0d expected below 150000", cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", {code_valid, code_out}, 9'h000);
        rst_n = 1'b1;
        running = 1;
        repeat (5) @(negedge clk);

        cur_req = "R2";
        send_frame(8'h1C, 0, 0);
        check("R2", {code_valid, code_out}, 9'h11C);

        cur_req = "R6";
        host_read();
        check("R6", {code_valid, code_out}, 9'h01C);

        cur_req = "R4";
        send_frame(8'hF0, 1, 0);
        check("R4", {code_valid, code_out}, 9'h1F0);

        cur_req = "R8";
        send_frame(8'hA5, 0, 0);
        check("R8", {code_valid, code_out}, 9'h1A5);
        host_read();

        cur_req = "R5";
        one_cell(1'b1, 0, 8'h00, 0);
        repeat (2 * HALF) @(negedge clk);
        check("R5", {code_valid, code_out}, 9'h0A5);
        send_frame(8'h3B, 0, 0);
        check("R5", {code_valid, code_out}, 9'h13B);
        host_read();

        cur_req = "R7";
        one_cell(1'b0, 0, 8'h00, 0);
        one_cell(1'b1, 0, 8'h00, 0);
        one_cell(1'b0, 0, 8'h00, 0);
        one_cell(1'b1, 0, 8'h00, 0);
        repeat (GAP + 2 * HALF) @(negedge clk);
        check("R7", {code_valid, code_out}, 9'h03B);
        send_frame(8'h81, 0, 0);
        check("R7", {code_valid, code_out}, 9'h181);
        host_read();

        cur_req = "R6";
        send_frame(8'h5A, 0, 1);
        check("R6", {code_valid, code_out}, 9'h15A);
        host_read();
        check("R6", {code_valid, code_out}, 9'h05A);

        cur_req = "R3";
        send_frame(8'h00, 1, 0);
        send_frame(8'hFF, 0, 0);
        check("R3", {code_valid, code_out}, 9'h1FF);

        repeat (10) @(negedge clk);
        finish_run();
    end

endmodule